// File: doc/BRIEF.md
# Shared Gray-Counter Ramp Converter Back End

This block is the digital side of a multi-channel ramp (Wilkinson) converter. One Gray-coded counter, `W` bits wide, is shared by `NCH` channels. While an external analog ramp rises, each channel's comparator flips when the ramp crosses that channel's held voltage. At that moment the channel copies the current count into its own result register. Gray coding matters because comparator edges are unrelated to the counting clock. Since only one counter bit changes per step, a copy taken near a counter transition is never more than one step from the true count.

A start pulse clears every channel, restarts the counter at zero and raises the ramp-enable and busy outputs for exactly `2**W` counting cycles. Each comparator is resynchronised through two flops, and only its first rising edge in a pass is recorded. When the count reaches its final value, any channel that has not fired is loaded with the full-scale code and marked as overflowed. Busy and ramp-enable then drop and a one-cycle done pulse follows. Results are read one channel at a time through an address port, in raw Gray form or converted to binary. With the default 50 MHz counting clock, a 12-bit pass takes about 82 µs.

Top module: `ramp_adc_backend`

## Requirements
- R1: While reset is asserted and after it is released, busy, ramp-enable and done are low, and every channel reads result 0 with its overflow flag clear.
- R2: A start pulse sampled while idle raises busy and ramp-enable on the next cycle. Both stay high for exactly 2**W cycles, and the counter starts at count zero.
- R3: During a pass, the internal counter changes in exactly one bit from each cycle to the next (Gray sequence g = b ^ (b >> 1)).
- R4: A comparator first sampled high at the clock edge that advances the count to n records count n+1. The extra step comes from the two synchronizer stages.
- R5: Only the first rising edge of a channel in a pass is recorded, and later toggles leave the result unchanged. A comparator already high when the pass starts produces no edge.
- R6: A channel that has not fired by the last count receives the full-scale code (binary 2**W-1, Gray 1 followed by W-1 zeros) with its overflow flag set. An edge recorded on the last count wins, and its flag stays clear.
- R7: In the cycle after the last count, done is high for exactly one cycle while busy and ramp-enable are low.
- R8: A start pulse during a pass is ignored: the pass length and the results are unaffected.
- R9: An accepted start clears all results to 0 and all overflow flags before the new pass captures anything.
- R10: A read returns its result one cycle after the address is sampled. The result is binary when the binary-select input is 1 and raw Gray when it is 0. An address of NCH or above reads 0 with the flag clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting and logic clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Begin a conversion pass (accepted only when idle) |
| cmp_i | input | NCH | Per-channel comparator levels, asynchronous |
| ramp_en_o | output | 1 | Enables the external ramp during the pass |
| busy_o | output | 1 | High for the whole counting window |
| done_o | output | 1 | One-cycle pulse at the end of the pass |
| rd_addr_i | input | AW | Channel address to read |
| rd_bin_i | input | 1 | 1 = return binary, 0 = return raw Gray |
| rd_data_o | output | W | Registered result of the addressed channel |
| rd_ovf_o | output | 1 | Registered overflow flag of the addressed channel |

## Verification
Busy and ramp-enable follow an accepted start by one edge. A comparator driven high just before the edge that moves the count to n shows up as result n+1, two edges later. Done rises on the edge after the last count, and a read answers one edge after its address is taken. The bench keeps a cycle index counted from the edge that takes start, drives inputs on falling edges, and samples on the falling edge at each of these exact offsets. Expected codes in the vector table are written as the index plus one.

// File: rtl/ramp_adc_pkg.sv
package ramp_adc_pkg;

  typedef enum logic {ST_IDLE, ST_CONV} conv_state_e;

  function automatic logic [31:0] gray_of(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [31:0] bin_of(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

endpackage

// File: rtl/ramp_gray_ctr.sv
module ramp_gray_ctr #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         en_i,
  output logic [W-1:0] gray_o,
  output logic         last_o
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  logic [W-1:0] bin_q, bin_d;

  always_comb begin
    bin_d = bin_q;
    if (clr_i)     bin_d = '0;
    else if (en_i) bin_d = bin_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bin_q <= '0;
    else        bin_q <= bin_d;
  end

  assign gray_o = bin_q ^ (bin_q >> 1);
  assign last_o = en_i && (bin_q == TOP);
endmodule

// File: rtl/ramp_adc_chan.sv
module ramp_adc_chan #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         busy_i,
  input  logic         last_i,
  input  logic [W-1:0] cnt_i,
  input  logic         cmp_i,
  output logic [W-1:0] code_o,
  output logic         cap_o,
  output logic         ovf_o
);
  localparam logic [W-1:0] FULL_GRAY = {1'b1, {(W-1){1'b0}}};

  logic       sync1_q, sync2_q, prev_q;
  logic       rise;
  logic [W-1:0] code_d;
  logic       cap_d, ovf_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
      prev_q  <= 1'b0;
    end else begin
      sync1_q <= cmp_i;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
    end
  end

  assign rise = sync2_q && !prev_q;

  always_comb begin
    code_d = code_o;
    cap_d  = cap_o;
    ovf_d  = ovf_o;
    if (clr_i) begin
      code_d = '0;
      cap_d  = 1'b0;
      ovf_d  = 1'b0;
    end else if (busy_i && !cap_o && rise) begin
      code_d = cnt_i;
      cap_d  = 1'b1;
    end else if (last_i && !cap_o) begin
      code_d = FULL_GRAY;
      ovf_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_o <= '0;
      cap_o  <= 1'b0;
      ovf_o  <= 1'b0;
    end else begin
      code_o <= code_d;
      cap_o  <= cap_d;
      ovf_o  <= ovf_d;
    end
  end
endmodule

// File: rtl/ramp_adc_rd.sv
module ramp_adc_rd
  import ramp_adc_pkg::*;
#(
  parameter int NCH = 36,
  parameter int W   = 12,
  parameter int AW  = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [AW-1:0]  addr_i,
  input  logic           bin_i,
  input  logic [NCH*W-1:0] codes_i,
  input  logic [NCH-1:0] ovf_i,
  output logic [W-1:0]   data_o,
  output logic           ovf_o
);
  logic [W-1:0] raw, data_d;
  logic         ovf_d;

  always_comb begin
    raw   = '0;
    ovf_d = 1'b0;
    if (32'(addr_i) < NCH) begin
      raw   = codes_i[32'(addr_i)*W +: W];
      ovf_d = ovf_i[addr_i];
    end
    data_d = bin_i ? W'(bin_of(32'(raw))) : raw;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_o <= '0;
      ovf_o  <= 1'b0;
    end else begin
      data_o <= data_d;
      ovf_o  <= ovf_d;
    end
  end
endmodule

// File: rtl/ramp_adc_backend.sv
module ramp_adc_backend
  import ramp_adc_pkg::*;
#(
  parameter  int NCH = 36,
  parameter  int W   = 12,
  localparam int AW  = (NCH > 1) ? $clog2(NCH + 1) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_i,
  input  logic [NCH-1:0] cmp_i,
  output logic           ramp_en_o,
  output logic           busy_o,
  output logic           done_o,
  input  logic [AW-1:0]  rd_addr_i,
  input  logic           rd_bin_i,
  output logic [W-1:0]   rd_data_o,
  output logic           rd_ovf_o
);
  logic [1:0]       rst_pipe_q;
  logic             rst_n_int;
  conv_state_e      state_q, state_d;
  logic             done_d;
  logic             accept, busy, last;
  logic [W-1:0]     cnt_gray;
  logic [NCH*W-1:0] code_v;
  logic [NCH-1:0]   cap_v, ovf_v;

  // reset: asserted at once, released after two clean edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_int = rst_pipe_q[1];

  assign busy   = (state_q == ST_CONV);
  assign accept = (state_q == ST_IDLE) && start_i;

  always_comb begin
    state_d = state_q;
    done_d  = 1'b0;
    case (state_q)
      ST_IDLE: if (start_i) state_d = ST_CONV;
      ST_CONV: if (last) begin
        state_d = ST_IDLE;
        done_d  = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      state_q <= ST_IDLE;
      done_o  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_o  <= done_d;
    end
  end

  assign busy_o    = busy;
  assign ramp_en_o = busy;

  ramp_gray_ctr #(.W(W)) u_ctr (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .clr_i  (accept),
    .en_i   (busy),
    .gray_o (cnt_gray),
    .last_o (last)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    ramp_adc_chan #(.W(W)) u_chan (
      .clk    (clk),
      .rst_n  (rst_n_int),
      .clr_i  (accept),
      .busy_i (busy),
      .last_i (last),
      .cnt_i  (cnt_gray),
      .cmp_i  (cmp_i[c]),
      .code_o (code_v[c*W +: W]),
      .cap_o  (cap_v[c]),
      .ovf_o  (ovf_v[c])
    );
  end

  ramp_adc_rd #(.NCH(NCH), .W(W), .AW(AW)) u_rd (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .addr_i  (rd_addr_i),
    .bin_i   (rd_bin_i),
    .codes_i (code_v),
    .ovf_i   (ovf_v),
    .data_o  (rd_data_o),
    .ovf_o   (rd_ovf_o)
  );
endmodule

// File: rtl/ramp_adc_chk.sv
module ramp_adc_chk #(
  parameter int NCH = 36,
  parameter int W   = 12
) (
  input logic           clk,
  input logic           rst_n,
  input logic           busy,
  input logic           ramp_en,
  input logic           done,
  input logic [W-1:0]   cnt,
  input logic [NCH-1:0] cap,
  input logic [NCH-1:0] ovf
);
  localparam logic [W:0] LAST_IDX = (W+1)'((1 << W) - 1);

  logic [W:0] cyc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cyc_q <= '0;
    else if (busy) cyc_q <= cyc_q + 1'b1;
    else           cyc_q <= '0;
  end

  p_start_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (cnt == '0));

  p_window_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(cyc_q) == LAST_IDX));

  p_ramp_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ramp_en == busy);

  p_gray_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($countones(cnt ^ $past(cnt)) == 1));

  p_first_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ((cap & $past(cap)) == $past(cap)));

  p_no_early_ovf_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (ovf == '0));

  p_all_resolved_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((cap | ovf) == {NCH{1'b1}}));

  p_done_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind ramp_adc_backend ramp_adc_chk #(.NCH(NCH), .W(W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n_int),
  .busy    (busy_o),
  .ramp_en (ramp_en_o),
  .done    (done_o),
  .cnt     (cnt_gray),
  .cap     (cap_v),
  .ovf     (ovf_v)
);

// File: tb/ramp_adc_backend_tb.sv
module ramp_adc_backend_tb;
  localparam int NCH = 36;
  localparam int W   = 12;
  localparam int AW  = $clog2(NCH + 1);
  localparam int LEN = 1 << W;
  localparam int FULL = LEN - 1;

  typedef struct packed {
    int ch;
    int rise;   // index k of edge before which cmp goes high; 0 = never
    int eb;     // expected binary result
    int eo;     // expected overflow flag
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{0,  1,    2,    0},
    '{1,  2,    3,    0},
    '{3,  100,  101,  0},
    '{5,  50,   51,   0},   // toggles later (R5)
    '{8,  1000, 1001, 0},
    '{12, 2047, 2048, 0},
    '{17, 2730, 2731, 0},
    '{20, 4000, 4001, 0},
    '{35, 4094, 4095, 0},   // lands on last count (R6)
    '{34, 4095, 4095, 1},   // one step too late (R6)
    '{2,  0,    4095, 1},
    '{30, 0,    4095, 1}
  };

  logic           clk;
  logic           rst_n;
  logic           start;
  logic [NCH-1:0] cmp;
  logic           ramp_en, busy, done;
  logic [AW-1:0]  rd_addr;
  logic           rd_bin;
  logic [W-1:0]   rd_data;
  logic           rd_ovf;

  int n_chk;
  int n_fail;

  ramp_adc_backend #(.NCH(NCH), .W(W)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start),
    .cmp_i     (cmp),
    .ramp_en_o (ramp_en),
    .busy_o    (busy),
    .done_o    (done),
    .rd_addr_i (rd_addr),
    .rd_bin_i  (rd_bin),
    .rd_data_o (rd_data),
    .rd_ovf_o  (rd_ovf)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic int gray(input int b);
    return b ^ (b >> 1);
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic read_chk(input int ch, input logic bin, input int eb, input int eo, input string tag);
    rd_addr = AW'(ch);
    rd_bin  = bin;
    @(negedge clk);
    check(tag, int'(rd_data), bin ? eb : gray(eb));
    check(tag, int'(rd_ovf), eo);
  endtask

  task automatic finish_up;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // conversion pass; conv_id selects extra directed stimulus
  task automatic run_pass(input int conv_id);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 1; k <= 4100; k++) begin
      if (conv_id == 1) begin
        for (int v = 0; v < NV; v++)
          if (VEC[v].rise == k) cmp[VEC[v].ch] = 1'b1;
        if (k == 300) cmp[5] = 1'b0;
        if (k == 400) cmp[5] = 1'b1;
      end else begin
        if (k == 500) cmp[9] = 1'b1;
        if (k == 10) begin rd_addr = AW'(3); rd_bin = 1'b1; end
        if (k == 11) begin
          check("R9 cleared result", int'(rd_data), 0);
          check("R9 cleared flag", int'(rd_ovf), 0);
        end
        start = (k == 1000);
      end
      if (k == 1) begin
        check("R2 busy after start", int'(busy), 1);
        check("R2 ramp after start", int'(ramp_en), 1);
      end
      if (k == LEN) begin
        check("R2 busy on last count", int'(busy), 1);
        check("R7 no early done", int'(done), 0);
      end
      if (k == LEN + 1) begin
        check("R7 done pulse", int'(done), 1);
        check("R7 busy low", int'(busy), 0);
        check("R7 ramp low", int'(ramp_en), 0);
      end
      if (k == LEN + 2) check("R7 done single", int'(done), 0);
      @(negedge clk);
    end
    start = 1'b0;
    cmp   = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R2 watchdog: actual=running expected=finished");
    finish_up();
  end

  initial begin
    n_chk   = 0;
    n_fail  = 0;
    rst_n   = 1'b0;
    start   = 1'b0;
    cmp     = '0;
    rd_addr = '0;
    rd_bin  = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 busy in reset", int'(busy), 0);
    check("R1 ramp in reset", int'(ramp_en), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 done after reset", int'(done), 0);
    read_chk(0, 1'b1, 0, 0, "R1 reset result");

    // pass 1: vector table
    run_pass(1);
    for (int v = 0; v < NV; v++) begin
      read_chk(VEC[v].ch, 1'b1, VEC[v].eb, VEC[v].eo, "R4 R6 binary result");
      read_chk(VEC[v].ch, 1'b0, VEC[v].eb, VEC[v].eo, "R10 gray result");
    end
    read_chk(5, 1'b1, 51, 0, "R5 later toggles ignored");
    read_chk(4, 1'b1, FULL, 1, "R6 silent channel");
    read_chk(NCH, 1'b1, 0, 0, "R10 address out of range");

    // pass 2: held-high comparator, restart ignored, clearing
    cmp[7] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    run_pass(2);
    read_chk(7, 1'b1, FULL, 1, "R5 held-high no edge");
    read_chk(9, 1'b1, 501, 0, "R8 result after ignored start");
    read_chk(3, 1'b1, FULL, 1, "R9 old result replaced");

    // reset mid-pass
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (20) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 async reset busy", int'(busy), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 busy after reset", int'(busy), 0);
    read_chk(9, 1'b1, 0, 0, "R1 result cleared by reset");
    finish_up();
  end
endmodule